// File: doc/BRIEF.md
# Self-Correcting Modulo-5 Counter (Dual Implementation)

This block is a three-bit synchronous counter that runs through the binary codes 0, 1, 2, 3 and 4 and then starts again at 0. Its next state is built twice inside one top module. The first form is a bank of JK-style flip-flops whose J and K inputs come from excitation equations. The second form is a bank of plain D registers whose next-state equations reach the same transitions. Both forms share one clock, one active-high synchronous reset and one count enable. A comparator raises a flag whenever the two counts differ.

The unused codes 5, 6 and 7 are never reached in normal counting. If one of them appears, the excitation logic itself sends the counter to 000 on the next enabled clock. No separate compare-and-clear path does this. A synchronous force-load input can write any code into both forms, which lets a test reach the illegal codes.

Top module: `mod5_pair`

## Requirements
- R1: With `cnt_en` high and `rst` and `force_ld` low, each rising clock edge advances both counts by one: 0 to 1, 1 to 2, 2 to 3 and 3 to 4.
- R2: With `cnt_en` high and `rst` and `force_ld` low, a count of 4 becomes 0 on the next rising edge.
- R3: With `cnt_en` high and `rst` and `force_ld` low, a count of 5, 6 or 7 becomes 0 on the next rising edge.
- R4: While `rst` is high, a rising edge sets both counts to 0. Reset takes priority over `force_ld` and `cnt_en`.
- R5: With `cnt_en`, `rst` and `force_ld` all low, both counts keep their value across a rising edge.
- R6: With `force_ld` high and `rst` low, a rising edge writes `force_val` into both counts, whatever the level of `cnt_en`.
- R7: Each bit of the JK form follows its J and K inputs. J=0, K=0 holds the bit. J=0, K=1 clears it. J=1, K=0 sets it. J=1, K=1 inverts it. The inputs per bit are: J0 = not q2, K0 = 1; J1 = (not q2) and q0, K1 = q2 or q0; J2 = q1 and q0, K2 = 1. Both J and K are forced to 0 while `cnt_en` is low.
- R8: `jk_count` and `d_count` are equal in every cycle. `mismatch` is high exactly when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| force_ld | input | 1 | Synchronous load of `force_val` into both forms |
| force_val | input | 3 | Code written when `force_ld` is high |
| jk_count | output | 3 | Registered count of the JK form |
| d_count | output | 3 | Registered count of the D form |
| mismatch | output | 1 | High while the two counts differ |

## Verification
Every count change caused by reset, load, enable or the input codes shows up on `jk_count` and `d_count` exactly one clock edge after the inputs that cause it. `mismatch` compares the two registered counts combinationally, so it follows that edge in the same cycle with no further delay. The bench changes its inputs one time unit after a rising edge and samples all three outputs one time unit after the next rising edge. Each check therefore looks at the single edge that its inputs govern.

// File: rtl/mod5_pkg.sv
package mod5_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned LAST_CODE = 4;
  typedef logic [STATE_W-1:0] mod5_t;
endpackage

// File: rtl/jk_bit.sv
module jk_bit #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic ld_val,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_VAL;
    else if (ld)    q <= ld_val;
    else begin
      case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end

  AST_JK_HOLD:   assert property (@(posedge clk) disable iff (rst) (!ld && !j && !k) |=> $stable(q)); // R7
  AST_JK_CLEAR:  assert property (@(posedge clk) disable iff (rst) (!ld && !j && k) |=> !q); // R7
  AST_JK_SET:    assert property (@(posedge clk) disable iff (rst) (!ld && j && !k) |=> q); // R7
  AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (rst) (!ld && j && k) |=> (q != $past(q))); // R7
endmodule

// File: rtl/mod5_jk_core.sv
module mod5_jk_core
  import mod5_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  ld,
  input  mod5_t ld_val,
  output mod5_t q
);
  logic [STATE_W-1:0] j_in;
  logic [STATE_W-1:0] k_in;
  logic qa, qb, qc;

  assign qa = q[0];
  assign qb = q[1];
  assign qc = q[2];

  // Excitation equations, gated by enable so a disabled counter holds
  always_comb begin
    j_in[0] = en & ~qc;
    k_in[0] = en;
    j_in[1] = en & ~qc & qa;
    k_in[1] = en & (qc | qa);
    j_in[2] = en & qb & qa;
    k_in[2] = en;
  end

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    jk_bit #(.RESET_VAL(1'b0)) u_ff (
      .clk   (clk),
      .rst   (rst),
      .ld    (ld),
      .ld_val(ld_val[i]),
      .j     (j_in[i]),
      .k     (k_in[i]),
      .q     (q[i])
    );
  end
endmodule

// File: rtl/mod5_d_core.sv
module mod5_d_core
  import mod5_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  ld,
  input  mod5_t ld_val,
  output mod5_t q
);
  mod5_t nxt;

  // Reduced next-state equations: any code with the top bit set goes to zero
  always_comb begin
    nxt[0] = ~q[2] & ~q[0];
    nxt[1] = ~q[2] & (q[1] ^ q[0]);
    nxt[2] = ~q[2] & q[1] & q[0];
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (en)  q <= nxt;
  end

  AST_D_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && (q < mod5_t'(LAST_CODE))) |=> (q == $past(q) + mod5_t'(1))); // R1
endmodule

// File: rtl/mod5_pair.sv
module mod5_pair
  import mod5_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               force_ld,
  input  logic [STATE_W-1:0] force_val,
  output logic [STATE_W-1:0] jk_count,
  output logic [STATE_W-1:0] d_count,
  output logic               mismatch
);
  mod5_jk_core u_jk (
    .clk   (clk),
    .rst   (rst),
    .en    (cnt_en),
    .ld    (force_ld),
    .ld_val(force_val),
    .q     (jk_count)
  );

  mod5_d_core u_d (
    .clk   (clk),
    .rst   (rst),
    .en    (cnt_en),
    .ld    (force_ld),
    .ld_val(force_val),
    .q     (d_count)
  );

  assign mismatch = (jk_count != d_count);

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !force_ld && jk_count == STATE_W'(LAST_CODE)) |=> (jk_count == '0)); // R2
  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !force_ld && jk_count > STATE_W'(LAST_CODE)) |=> (jk_count == '0)); // R3
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (jk_count == '0 && d_count == '0)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !force_ld) |=> ($stable(jk_count) && $stable(d_count))); // R5
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    force_ld |=> (jk_count == $past(force_val) && d_count == $past(force_val))); // R6
  AST_FORMS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (jk_count == d_count)); // R8
endmodule

// File: tb/mod5_pair_test.sv
module mod5_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;
  // Layout: {rst, en, ld, val[2:0], expected[2:0], requirement[3:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 4'd4},  // R4 reset
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd1, 4'd1},  // R1
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd2, 4'd1},  // R1
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd3, 4'd1},  // R1
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd4, 4'd1},  // R1
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 4'd2},  // R2 wrap
    {1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 4'd5},  // R5 hold
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd1, 4'd1},  // R1
    {1'b0, 1'b0, 1'b0, 3'd6, 3'd1, 4'd5},  // R5 hold, val ignored
    {1'b0, 1'b0, 1'b1, 3'd5, 3'd5, 4'd6},  // R6 load 5, enable low
    {1'b0, 1'b0, 1'b0, 3'd0, 3'd5, 4'd5},  // R5 illegal code held
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 4'd3},  // R3 5 -> 0
    {1'b0, 1'b1, 1'b1, 3'd6, 3'd6, 4'd6},  // R6 load 6, enable high
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 4'd3},  // R3 6 -> 0
    {1'b0, 1'b1, 1'b1, 3'd7, 3'd7, 4'd6},  // R6 load 7
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 4'd3},  // R3 7 -> 0
    {1'b0, 1'b1, 1'b1, 3'd3, 3'd3, 4'd6},  // R6 load 3
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd4, 4'd7},  // R7 3 -> 4 through bit-2 set
    {1'b1, 1'b1, 1'b1, 3'd7, 3'd0, 4'd4},  // R4 reset beats load
    {1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 4'd6},  // R6
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd3, 4'd7}   // R7 bit-0 set, bit-1 hold
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       force_ld = 1'b0;
  logic [2:0] force_val = 3'd0;
  logic [2:0] jk_count;
  logic [2:0] d_count;
  logic       mismatch;
  int         n_checks = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod5_pair uut (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .force_ld (force_ld),
    .force_val(force_val),
    .jk_count (jk_count),
    .d_count  (d_count),
    .mismatch (mismatch)
  );

  task automatic check(input logic [2:0] exp, input int req);
    n_checks++;
    if (jk_count !== exp) begin
      n_fail++;
      $display("FAIL R%0d jk_count actual %0d expected %0d", req, jk_count, exp);
    end
    n_checks++;
    if (d_count !== exp) begin
      n_fail++;
      $display("FAIL R%0d d_count actual %0d expected %0d", req, d_count, exp);
    end
    n_checks++;
    if (mismatch !== 1'b0) begin  // R8
      n_fail++;
      $display("FAIL R8 mismatch actual %0b expected 0", mismatch);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic l, input logic [2:0] v);
    rst = r; cnt_en = e; force_ld = l; force_val = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] model_next(input logic [2:0] c);
    return (c >= 3'd4) ? 3'd0 : c + 3'd1;
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [2:0] model;
    @(posedge clk);
    #1;
    check(3'd0, 4);  // R4 reset state
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:7]);
      check(VEC[i][6:4], int'(VEC[i][3:0]));
    end

    // R1 R2 long enabled run against a bench model
    model = 3'd3;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b1, 1'b0, 3'd0);
      model = model_next(model);
      check(model, 1);
    end

    // R5 an illegal code held for several idle cycles, then recovers (R3)
    step(1'b0, 1'b0, 1'b1, 3'd6);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b0, 3'd1);
      check(3'd6, 5);
    end
    step(1'b0, 1'b1, 1'b0, 3'd0);
    check(3'd0, 3);

    // R4 reset from mid-count with enable high
    step(1'b0, 1'b1, 1'b0, 3'd0);
    step(1'b0, 1'b1, 1'b0, 3'd0);
    check(3'd2, 1);
    step(1'b1, 1'b1, 1'b0, 3'd0);
    check(3'd0, 4);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule